// File: doc/BRIEF.md
# Descriptor-Ring I2C Master Transfer Engine

This block carries out queued I2C master transfers that software describes in two small rings of buffer descriptors held in a local memory: one ring for bytes going out and one for bytes coming in. Every descriptor occupies four 16-bit words: a status word, a length word, a buffer pointer and a spare word. Each byte of a buffer sits in the low eight bits of one memory word. Software fills the descriptors and hands each one to the engine by setting its ownership bit. It then sets the enable bit and writes the launch command. The engine walks the transmit ring from its base. It emits START and STOP conditions as the flags of each descriptor ask, and when a transfer reads it routes the received bytes into the current receive descriptor. When a descriptor finishes, the engine writes back its status with ownership returned and any error code set.

Bit timing is left to an external byte shifter. The engine gives it one command at a time (START, write a byte, read a byte, STOP). The shifter answers with a done pulse, the sampled acknowledge, a collision flag and the received byte.

Top module: `i2cq_engine`

## Requirements
- R1: After reset the engine is idle: `busy` is low, no shifter command is issued and no memory write occurs.
- R2: Register select 0 holds the mode, where bit 0 is enable. Writing select 1 with data bit 7 set launches a run only while enable is set. With enable clear the write has no effect and descriptors stay untouched.
- R3: Every launch starts at descriptor 0 of both rings. Transmit descriptor i sits at word TX_BASE+4*i and receive descriptor i at RX_BASE+4*i, with status at offset 0, length at offset 1 and pointer at offset 2.
- R4: For a transmit descriptor that has status bit 10 set, a START condition comes before its first byte. Its bytes go out in buffer order. Status bit 11 adds a STOP after the final byte.
- R5: When a descriptor completes, its status is rewritten with bit 15 cleared, the other flags kept and an error code in bits 2:0. The walk then moves to the next descriptor and ends at the first one whose bit 15 is clear. Status bit 13, or reaching index 3, returns the ring to index 0.
- R6: A NAK on an address or write byte sets status bit 2, is followed by a STOP, and halts the ring.
- R7: A collision reported by the shifter sets status bit 0, issues no STOP, and halts the ring.
- R8: A transmit descriptor of length 0 gets status bit 1 (underrun) and halts the ring.
- R9: If the first byte of a START descriptor has bit 0 set, the remaining length−1 slots are reads. The received bytes go in order into the buffer of the current receive descriptor, whose status is then rewritten with bit 15 (empty) cleared.
- R10: A byte is dropped and receive status bit 1 (overrun) is set if the byte arrives while the receive descriptor was not empty, or after min(length, 128) bytes have already been stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = mode register, 1 = command register |
| reg_wdata | input | 8 | Register write data |
| busy | output | 1 | A run is in progress |
| mem_addr | output | AW | Descriptor/byte memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after the address |
| sh_valid | output | 1 | Shifter command strobe |
| sh_op | output | 2 | 0 START, 1 write byte, 2 read byte, 3 STOP |
| sh_wdata | output | 8 | Byte to write |
| sh_rd_last | output | 1 | Read byte is the last of its descriptor (master NAKs it) |
| sh_done | input | 1 | Shifter finished the command |
| sh_nak | input | 1 | Acknowledge sampled high on a written byte |
| sh_col | input | 1 | Bus collision seen |
| sh_rdata | input | 8 | Byte read from the bus |

## Verification
The bench builds the engine with its defaults: 9-bit word addresses, transmit ring at word 0, receive ring at word 16, four descriptors per ring and a 128-byte receive limit. The 512-word memory leaves room for a read transfer of 130 bytes into a receive descriptor that claims 200. That makes the 128-byte clamp reachable. With four descriptors, a chain of four owned descriptors walks off the end of the ring by index alone. A behavioural target answers only one address, so NAK, collision, underrun, overrun and random write-then-read sequences can all be checked against a shadow copy of the target's registers.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  localparam int OWN_B   = 15;
  localparam int WRAP_B  = 13;
  localparam int LAST_B  = 11;
  localparam int START_B = 10;

  localparam logic [15:0] E_COL = 16'h0001;
  localparam logic [15:0] E_UND = 16'h0002;
  localparam logic [15:0] E_NAK = 16'h0004;
  localparam logic [15:0] E_OVR = 16'h0002;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } sh_op_e;

  // usable receive length after the hard cap
  function automatic logic [15:0] rx_cap(input logic [15:0] len, input logic [15:0] maxlen);
    return (len > maxlen) ? maxlen : len;
  endfunction

  // completed status word: ownership returned, old error field replaced
  function automatic logic [15:0] close_word(input logic [15:0] st, input logic [15:0] err);
    return (st & ~16'h8007) | err;
  endfunction
endpackage

// File: rtl/i2cq_ring.sv
module i2cq_ring #(
  parameter int DEPTH = 4,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          advance,
  input  logic          wrap_req,
  output logic [IW-1:0] idx
);
  always_ff @(posedge clk) begin
    if (!rst_n)       idx <= '0;
    else if (restart) idx <= '0;
    else if (advance) idx <= (wrap_req || idx == IW'(DEPTH - 1)) ? '0 : idx + 1'b1;
  end

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart && wrap_req) |=> idx == '0);
endmodule

// File: rtl/i2cq_rxgate.sv
module i2cq_rxgate
  import i2cq_pkg::*;
#(
  parameter int MAXLEN = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        load_empty,
  input  logic [15:0] load_len,
  input  logic        take,
  output logic        accept,
  output logic        ovr,
  output logic [15:0] rcnt
);
  logic [15:0] lim;
  logic        en;

  assign accept = en && (rcnt < lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcnt <= '0; lim <= '0; en <= 1'b0; ovr <= 1'b0;
    end else if (load) begin
      rcnt <= '0;
      lim  <= rx_cap(load_len, 16'(MAXLEN));
      en   <= load_empty;
      ovr  <= 1'b0;
    end else if (take) begin
      if (accept) rcnt <= rcnt + 16'd1;
      else        ovr  <= 1'b1;
    end
  end

  // R10
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) rcnt <= lim);
  // R10
  rx_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !load && !accept) |=> ovr);
endmodule

// File: rtl/i2cq_engine.sv
module i2cq_engine
  import i2cq_pkg::*;
#(
  parameter int AW      = 9,
  parameter int TX_BASE = 0,
  parameter int RX_BASE = 16,
  parameter int RING    = 4,
  parameter int RX_MAX  = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic          reg_sel,
  input  logic [7:0]    reg_wdata,
  output logic          busy,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          sh_valid,
  output logic [1:0]    sh_op,
  output logic [7:0]    sh_wdata,
  output logic          sh_rd_last,
  input  logic          sh_done,
  input  logic          sh_nak,
  input  logic          sh_col,
  input  logic [7:0]    sh_rdata
);
  localparam int IW = $clog2(RING);

  typedef enum logic [4:0] {
    S_IDLE, S_TS, S_TL, S_TP, S_CHK, S_STW, S_BRD, S_BGO, S_BW,
    S_RS, S_RL, S_RP, S_RQ, S_SPW, S_CLT, S_CLR, S_ADV
  } st_e;

  st_e st;
  logic          mode_en, rd_mode, cur_rd, rx_used;
  logic [15:0]   tst, tlen, cnt, errs, rst_r, rlen;
  logic [AW-1:0] tptr, rptr, tdesc, rdesc;
  logic [IW-1:0] tidx, ridx;
  logic          rx_accept, rx_ovr;
  logic [15:0]   rcnt;

  // named events for assertions and sub-blocks
  logic go_fire, byte_done, nak_evt, col_evt, rx_take, need_rx, last_byte, tx_close_wr, halt_evt;
  logic unused_bits;

  assign unused_bits = ^reg_wdata[6:1];
  assign busy        = (st != S_IDLE);
  assign go_fire     = reg_we && reg_sel && reg_wdata[7] && mode_en && (st == S_IDLE);
  assign byte_done   = (st == S_BW) && sh_done;
  assign col_evt     = byte_done && sh_col;
  assign nak_evt     = byte_done && !sh_col && !cur_rd && sh_nak;
  assign rx_take     = byte_done && !sh_col && cur_rd;
  assign last_byte   = (cnt + 16'd1) == tlen;
  assign need_rx     = rd_mode && (cnt == 16'd0) && (tlen > 16'd1);
  assign tx_close_wr = (st == S_CLT);
  assign halt_evt    = (st == S_ADV) && (errs != 16'd0);
  assign tdesc       = AW'(TX_BASE) + (AW'(tidx) << 2);
  assign rdesc       = AW'(RX_BASE) + (AW'(ridx) << 2);

  i2cq_ring #(.DEPTH(RING)) u_txring (
    .clk(clk), .rst_n(rst_n), .restart(go_fire), .advance(st == S_ADV),
    .wrap_req(tst[WRAP_B]), .idx(tidx));

  i2cq_ring #(.DEPTH(RING)) u_rxring (
    .clk(clk), .rst_n(rst_n), .restart(go_fire), .advance((st == S_ADV) && rx_used),
    .wrap_req(rst_r[WRAP_B]), .idx(ridx));

  i2cq_rxgate #(.MAXLEN(RX_MAX)) u_rxgate (
    .clk(clk), .rst_n(rst_n), .load(st == S_RQ), .load_empty(rst_r[OWN_B]),
    .load_len(rlen), .take(rx_take), .accept(rx_accept), .ovr(rx_ovr), .rcnt(rcnt));

  always_comb begin
    mem_addr   = tdesc;
    mem_we     = 1'b0;
    mem_wdata  = 16'h0;
    sh_valid   = 1'b0;
    sh_op      = OP_WRITE;
    sh_wdata   = 8'h0;
    sh_rd_last = 1'b0;
    case (st)
      S_TL:  mem_addr = tdesc + AW'(1);
      S_TP:  mem_addr = tdesc + AW'(2);
      S_CHK: if (tst[OWN_B] && tlen != 16'd0 && tst[START_B]) begin
               sh_valid = 1'b1; sh_op = OP_START;
             end
      S_BRD: mem_addr = tptr + AW'(cnt);
      S_BGO: begin
               sh_valid   = 1'b1;
               sh_op      = (rd_mode && cnt != 16'd0) ? OP_READ : OP_WRITE;
               sh_wdata   = mem_rdata[7:0];
               sh_rd_last = last_byte;
             end
      S_RS:  mem_addr = rdesc;
      S_RL:  mem_addr = rdesc + AW'(1);
      S_RP:  mem_addr = rdesc + AW'(2);
      S_BW:  begin
               if (rx_take && rx_accept) begin
                 mem_we    = 1'b1;
                 mem_addr  = rptr + AW'(rcnt);
                 mem_wdata = {8'h00, sh_rdata};
               end
               if (nak_evt || (byte_done && !sh_col && !need_rx && last_byte && tst[LAST_B])) begin
                 sh_valid = 1'b1; sh_op = OP_STOP;
               end
             end
      S_CLT: begin mem_we = 1'b1; mem_wdata = close_word(tst, errs); end
      S_CLR: begin
               mem_we = 1'b1; mem_addr = rdesc;
               mem_wdata = close_word(rst_r, rx_ovr ? E_OVR : 16'h0);
             end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; mode_en <= 1'b0; rd_mode <= 1'b0; cur_rd <= 1'b0; rx_used <= 1'b0;
      tst <= '0; tlen <= '0; cnt <= '0; errs <= '0; rst_r <= '0; rlen <= '0;
      tptr <= '0; rptr <= '0;
    end else begin
      if (reg_we && !reg_sel) mode_en <= reg_wdata[0];
      case (st)
        S_IDLE: if (go_fire) st <= S_TS;
        S_TS:   st <= mode_en ? S_TL : S_IDLE;
        S_TL:   begin tst <= mem_rdata; st <= S_TP; end
        S_TP:   begin tlen <= mem_rdata; st <= S_CHK; end
        S_CHK:  begin
                  tptr <= mem_rdata[AW-1:0]; cnt <= '0; errs <= '0;
                  rd_mode <= 1'b0; rx_used <= 1'b0;
                  if (!tst[OWN_B])          st <= S_IDLE;
                  else if (tlen == 16'd0)   begin errs <= E_UND; st <= S_CLT; end
                  else if (tst[START_B])    st <= S_STW;
                  else                      st <= S_BRD;
                end
        S_STW:  if (sh_done) begin
                  if (sh_col) begin errs <= E_COL; st <= S_CLT; end
                  else st <= S_BRD;
                end
        S_BRD:  st <= S_BGO;
        S_BGO:  begin
                  cur_rd <= rd_mode && (cnt != 16'd0);
                  if (cnt == 16'd0 && tst[START_B]) rd_mode <= mem_rdata[0];
                  st <= S_BW;
                end
        S_BW:   if (sh_done) begin
                  if (col_evt)      begin errs <= E_COL; st <= S_CLT; end
                  else if (nak_evt) begin errs <= E_NAK; st <= S_SPW; end
                  else begin
                    cnt <= cnt + 16'd1;
                    if (need_rx)        st <= S_RS;
                    else if (last_byte) st <= tst[LAST_B] ? S_SPW : S_CLT;
                    else                st <= S_BRD;
                  end
                end
        S_RS:   st <= S_RL;
        S_RL:   begin rst_r <= mem_rdata; st <= S_RP; end
        S_RP:   begin rlen <= mem_rdata; st <= S_RQ; end
        S_RQ:   begin rptr <= mem_rdata[AW-1:0]; rx_used <= 1'b1; st <= S_BRD; end
        S_SPW:  if (sh_done) st <= S_CLT;
        S_CLT:  st <= rx_used ? S_CLR : S_ADV;
        S_CLR:  st <= S_ADV;
        S_ADV:  st <= (errs != 16'd0) ? S_IDLE : S_TS;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) go_fire |=> busy);
  // R4
  start_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_valid && sh_op == 2'(OP_START)) |-> tst[START_B]);
  // R6
  nak_stop_chk: assert property (@(posedge clk) disable iff (!rst_n) nak_evt |=> st == S_SPW);
  // R6
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n) halt_evt |=> !busy);
  // R5
  close_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SPW && sh_done) |=> tx_close_wr);
endmodule

// File: tb/sim_i2cq_engine.sv
module sim_i2cq_engine;
  localparam int CLK_P = 10;
  localparam logic [6:0] TGT = 7'h50;
  localparam logic [15:0] OWN = 16'h8000, WRP = 16'h2000, LST = 16'h0800, STA = 16'h0400;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0, reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic busy, mem_we, sh_valid, sh_rd_last;
  logic [8:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [1:0] sh_op;
  logic [7:0] sh_wdata, sh_rdata;
  logic sh_done, sh_nak, sh_col;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [15:0] mem [512];
  logic hw_en = 0;
  logic [8:0] hw_addr = 0;
  logic [15:0] hw_data = 0;
  logic [7:0] tmem [256];
  logic [7:0] exp_t [256];
  logic inj_col = 0;
  int pend, n_start, n_stop;
  logic [1:0] tphase;
  logic tsel;
  logic [7:0] treg;

  always #(CLK_P/2) clk = ~clk;

  i2cq_engine u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .busy(busy), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .sh_valid(sh_valid), .sh_op(sh_op), .sh_wdata(sh_wdata), .sh_rd_last(sh_rd_last),
    .sh_done(sh_done), .sh_nak(sh_nak), .sh_col(sh_col), .sh_rdata(sh_rdata));

  function automatic logic [7:0] tinit(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    else if (hw_en) mem[hw_addr] <= hw_data;
    mem_rdata <= mem[mem_addr];
  end

  // byte shifter plus behavioural target
  always @(posedge clk) begin
    if (!rst_n) begin
      sh_done <= 0; sh_nak <= 0; sh_col <= 0; sh_rdata <= 0; pend <= 0;
      n_start <= 0; n_stop <= 0; tphase <= 0; tsel <= 0; treg <= 0;
      for (int i = 0; i < 256; i++) tmem[i] <= tinit(i);
    end else begin
      sh_done <= 0;
      if (pend != 0) begin
        pend <= pend - 1;
        if (pend == 1) sh_done <= 1;
      end else if (sh_valid) begin
        pend <= 2; sh_col <= 0; sh_nak <= 0;
        case (sh_op)
          2'd0: begin n_start <= n_start + 1; tphase <= 0; end
          2'd1: if (tphase == 0) begin
                  tsel <= (sh_wdata[7:1] == TGT); sh_nak <= (sh_wdata[7:1] != TGT); tphase <= 1;
                end else if (inj_col) sh_col <= 1;
                else if (!tsel) sh_nak <= 1;
                else if (tphase == 1) begin treg <= sh_wdata; tphase <= 2; end
                else begin tmem[treg] <= sh_wdata; treg <= treg + 1; end
          2'd2: begin sh_rdata <= tmem[treg]; treg <= treg + 1; end
          default: n_stop <= n_stop + 1;
        endcase
      end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_word(input int a, input logic [15:0] d);
    @(negedge clk); hw_en = 1; hw_addr = 9'(a); hw_data = d;
    @(negedge clk); hw_en = 0;
  endtask

  task automatic reg_wr(input logic s, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic set_tx(input int i, input logic [15:0] st, input int len, input int ptr);
    wr_word(4*i, st); wr_word(4*i+1, 16'(len)); wr_word(4*i+2, 16'(ptr));
  endtask

  task automatic set_rx(input int i, input logic [15:0] st, input int len, input int ptr);
    wr_word(16+4*i, st); wr_word(16+4*i+1, 16'(len)); wr_word(16+4*i+2, 16'(ptr));
  endtask

  task automatic run;
    reg_wr(1'b1, 8'h80);
    repeat (2) @(negedge clk);
    for (int k = 0; k < 20000 && busy; k++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int s0, st0, sp0, r, len;
    logic [7:0] d;
    s0 = $urandom(32'd1234);
    for (int i = 0; i < 256; i++) exp_t[i] = tinit(i);
    for (int i = 0; i < 512; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", 16'(busy), 0);
    check("R1 sh_valid", 16'(sh_valid), 0);
    check("R1 mem_we", 16'(mem_we), 0);

    // R2: launch with enable clear is ignored
    set_tx(0, OWN|STA|LST|WRP, 4, 64);
    wr_word(64, 16'hA0); wr_word(65, 16'h10); wr_word(66, 16'h11); wr_word(67, 16'h22);
    reg_wr(1'b1, 8'h80);
    repeat (4) @(negedge clk);
    check("R2 disabled busy", 16'(busy), 0);
    check("R2 disabled status", mem[0], OWN|STA|LST|WRP);

    // R4/R5 plain write
    reg_wr(1'b0, 8'h01);
    st0 = n_start; sp0 = n_stop;
    run();
    exp_t[8'h10] = 8'h11; exp_t[8'h11] = 8'h22;
    check("R4 target byte0", 16'(tmem[8'h10]), 16'(exp_t[8'h10]));
    check("R4 target byte1", 16'(tmem[8'h11]), 16'(exp_t[8'h11]));
    check("R5 close status", mem[0], STA|LST|WRP);
    check("R4 starts", 16'(n_start - st0), 1);
    check("R4 stops", 16'(n_stop - sp0), 1);

    // R9 write-then-read
    set_tx(0, OWN|STA, 2, 64); wr_word(64, 16'hA0); wr_word(65, 16'h20);
    set_tx(1, OWN|STA|LST|WRP, 6, 80); wr_word(80, 16'hA1);
    for (int k = 1; k < 6; k++) wr_word(80+k, 16'h0);
    set_rx(0, OWN|WRP, 5, 256);
    for (int k = 0; k < 5; k++) wr_word(256+k, 16'h0);
    st0 = n_start; sp0 = n_stop;
    run();
    for (int k = 0; k < 5; k++) check("R9 rx byte", mem[256+k], 16'(exp_t[8'h20+k]));
    check("R9 rx status", mem[16], WRP);
    check("R5 desc0 status", mem[0], STA);
    check("R5 desc1 status", mem[4], STA|LST|WRP);
    check("R4 restart count", 16'(n_start - st0), 2);
    check("R4 stop count", 16'(n_stop - sp0), 1);

    // R6 NAK halts ring
    set_tx(0, OWN|STA, 3, 64); wr_word(64, 16'hB0);
    set_tx(1, OWN|STA|LST|WRP, 2, 80);
    sp0 = n_stop;
    run();
    check("R6 nak status", mem[0], STA|16'h0004);
    check("R6 ring halted", mem[4], OWN|STA|LST|WRP);
    check("R6 stop after nak", 16'(n_stop - sp0), 1);

    // R8 underrun; also R3 restart from base after halt at index 1
    set_tx(0, OWN|LST|WRP, 0, 64);
    run();
    check("R8 underrun status", mem[0], LST|WRP|16'h0002);
    check("R3 desc1 untouched", mem[4], OWN|STA|LST|WRP);

    // R7 collision
    inj_col = 1;
    set_tx(0, OWN|STA|LST|WRP, 3, 64); wr_word(64, 16'hA0); wr_word(65, 16'h30); wr_word(66, 16'h55);
    sp0 = n_stop;
    run();
    inj_col = 0;
    check("R7 col status", mem[0], STA|LST|WRP|16'h0001);
    check("R7 no stop", 16'(n_stop - sp0), 0);

    // R10 overrun: receive descriptor not empty
    set_tx(0, OWN|STA|LST|WRP, 4, 64); wr_word(64, 16'hA1);
    set_rx(0, WRP, 3, 256);
    for (int k = 0; k < 3; k++) wr_word(256+k, 16'h00EE);
    run();
    check("R10 ovr status", mem[16], WRP|16'h0002);
    check("R10 buffer kept", mem[256], 16'h00EE);

    // R10 cap at 128
    set_tx(0, OWN|STA, 2, 64); wr_word(64, 16'hA0); wr_word(65, 16'h00);
    set_tx(1, OWN|STA|LST|WRP, 131, 100); wr_word(100, 16'hA1);
    set_rx(0, OWN|WRP, 200, 256);
    for (int k = 0; k < 130; k++) wr_word(256+k, 16'h00EE);
    run();
    check("R10 byte 0", mem[256], 16'(exp_t[0]));
    check("R10 byte 127", mem[256+127], 16'(exp_t[127]));
    check("R10 byte 128 dropped", mem[256+128], 16'h00EE);
    check("R10 cap status", mem[16], WRP|16'h0002);

    // R5 ring walks four descriptors and wraps by index
    for (int i = 0; i < 4; i++) begin
      set_tx(i, OWN|STA|LST, 3, 64+4*i);
      wr_word(64+4*i, 16'hA0); wr_word(65+4*i, 16'(8'h40+i)); wr_word(66+4*i, 16'(8'h90+i));
    end
    sp0 = n_stop;
    run();
    for (int i = 0; i < 4; i++) begin
      exp_t[8'h40+i] = 8'(8'h90+i);
      check("R5 ring status", mem[4*i], STA|LST);
      check("R5 ring data", 16'(tmem[8'h40+i]), 16'(exp_t[8'h40+i]));
    end
    check("R5 ring stops", 16'(n_stop - sp0), 4);

    // random write then read-back
    for (int it = 0; it < 6; it++) begin
      r = $urandom % 200; len = 1 + ($urandom % 4);
      set_tx(0, OWN|STA|LST|WRP, 2+len, 64); wr_word(64, 16'hA0); wr_word(65, 16'(r));
      for (int k = 0; k < len; k++) begin
        d = 8'($urandom); exp_t[r+k] = d; wr_word(66+k, 16'(d));
      end
      run();
      check("R4 rand status", mem[0], STA|LST|WRP);
      for (int k = 0; k < len; k++) check("R4 rand target", 16'(tmem[r+k]), 16'(exp_t[r+k]));
      set_tx(0, OWN|STA, 2, 64); wr_word(65, 16'(r));
      set_tx(1, OWN|STA|LST|WRP, 1+len, 80); wr_word(80, 16'hA1);
      set_rx(0, OWN|WRP, len, 256);
      run();
      for (int k = 0; k < len; k++) check("R9 rand readback", mem[256+k], 16'(exp_t[r+k]));
      check("R9 rand rx status", mem[16], WRP);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule